// File: doc/BRIEF.md
# Smart Card Channel Transmit-End and Parity-Error Flags

This block keeps the status flags of a half-duplex smart card serial channel. It counts half elementary time units (half-etu ticks) from the start of each transmitted character and, when the interval for the current guard and block setting runs out, raises the transmit-end flag. The flag rises only if the receiving side has not signalled an error and the transmit data register is already empty.

The block also owns the parity-error and error-signal flags. Each of these flags is cleared by software only by writing 0 after it has been read as 1. A received byte that arrives with a parity error is still passed to the receive data register, but the receive-full strobe stays low. The parity-error flag then halts further reception until software clears it. Serialisation, clock generation and the driving of the error signal belong to neighbouring blocks.

Top module: `sc_stat_flags`

## Requirements
- R1: After reset, `tend` is 1 and `per_flag`, `ers_flag`, `rx_halt`, `rdr_load` and `rdrf_set` are 0.
- R2: With `guard_mode`=0 and `block_mode`=0, the interval is 25 `half_tick` pulses after `tx_start`. `tend` becomes 1 in the cycle after the 25th tick (with `tx_en`=1, `ers_flag`=0, `tdr_empty`=1) and is still 0 after the 24th tick.
- R3: With `guard_mode`=0 and `block_mode`=1, the interval is 23 half ticks.
- R4: With `guard_mode`=1, the interval is 22 half ticks whatever the value of `block_mode`.
- R5: If `tdr_empty`=0 or `ers_flag`=1 in the cycle the interval expires, `tend` is not set, either then or on later ticks.
- R6: While `tx_en`=0 and `ers_flag`=0, `tend` is 1 from the next cycle on.
- R7: With `tx_en`=1, `tend` clears after a `tdr_wr` pulse. It also clears after a status write with bit 0 = 0, provided a status read (`stat_rd`) with `tdr_empty`=1 came first. Such a write with no prior arming read leaves `tend` unchanged.
- R8: A `tx_start` pulse restarts the interval count from zero and drops any evaluation still pending for the earlier character.
- R9: A `rx_valid` pulse with `par_err`=1, while `per_flag`=0, gives the following in the next cycle: `per_flag`=1, `rdr_load`=1, `rdr_data` equal to the received byte, and `rdrf_set`=0. A byte received without error gives both `rdr_load` and `rdrf_set`.
- R10: While `per_flag`=1, `rx_halt` is 1 and a received byte produces no `rdr_load`.
- R11: `per_flag` clears only on a status write with bit 1 = 0 that follows a status read made while the flag was 1. A write with bit 1 = 1, or a write of 0 with no arming read, leaves it set.
- R12: An `err_sig` pulse sets `ers_flag`. The flag clears only on a status write with bit 2 = 0 after an arming read. While the flag is set, `tend` is neither held by `tx_en`=0 nor set at expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One pulse per half etu |
| tx_start | input | 1 | Start of a character transmission |
| tx_en | input | 1 | Transmitter enable |
| guard_mode | input | 1 | Guard-time mode select |
| block_mode | input | 1 | Block-transfer mode select |
| tdr_empty | input | 1 | Transmit data register empty status |
| tdr_wr | input | 1 | Transmit data register written by DMA or CPU |
| err_sig | input | 1 | Error signal returned by the receiver |
| rx_valid | input | 1 | Received byte strobe |
| par_err | input | 1 | Parity error on the byte strobed by rx_valid |
| rx_byte | input | DATA_W | Received byte |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | STAT_W | Status write data (bit0 empty-clear, bit1 parity, bit2 error signal) |
| tend | output | 1 | Transmit-end flag |
| ers_flag | output | 1 | Error-signal flag |
| per_flag | output | 1 | Parity-error flag |
| rx_halt | output | 1 | Reception blocked |
| rdr_load | output | 1 | Receive data register load strobe |
| rdrf_set | output | 1 | Receive-full set strobe |
| rdr_data | output | DATA_W | Byte to load into the receive data register |

## Verification
The bench builds the block with its default parameters: intervals of 25, 23 and 22 half ticks and an 8-bit data path. With these values every interval setting, including a restart part-way through an interval, fits in a few hundred cycles. Random gaps between ticks and random mode choices show that the flag rises exactly on the last tick and not one tick before. Random bytes exercise the receive load path both with and without parity errors.

// File: rtl/sc_stat_pkg.sv
package sc_stat_pkg;
    localparam int STAT_W   = 3;
    localparam int BIT_TDRE = 0;
    localparam int BIT_PER  = 1;
    localparam int BIT_ERS  = 2;

    typedef struct packed {
        logic flag;
        logic armed;
    } armed_flag_t;
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
    parameter int unsigned TGT_STD = 25,
    parameter int unsigned TGT_BLK = 23,
    parameter int unsigned TGT_GRD = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic guard_mode,
    input  logic block_mode,
    output logic expire
);
    localparam int unsigned TGT_M1  = (TGT_STD > TGT_BLK) ? TGT_STD : TGT_BLK;
    localparam int unsigned TGT_MAX = (TGT_M1 > TGT_GRD) ? TGT_M1 : TGT_GRD;
    localparam int unsigned CNT_W   = $clog2(TGT_MAX + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             s_q, s_d;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        if (guard_mode)      last_d = CNT_W'(TGT_GRD - 1);
        else if (block_mode) last_d = CNT_W'(TGT_BLK - 1);
        else                 last_d = CNT_W'(TGT_STD - 1);

        s_d    = s_q;
        expire = 1'b0;
        if (start) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
        end else if (s_q.active && tick) begin
            if (s_q.cnt == last_d) begin
                expire     = 1'b1;
                s_d.active = 1'b0;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sc_armed_flag.sv
module sc_armed_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic flag
);
    import sc_stat_pkg::*;

    armed_flag_t s_q, s_d;
    logic        clr_d;

    always_comb begin
        s_d   = s_q;
        clr_d = wr && !wbit && s_q.armed;
        if (clr_d) begin
            s_d.flag  = 1'b0;
            s_d.armed = 1'b0;
        end else if (rd && s_q.flag) begin
            s_d.armed = 1'b1;
        end
        if (set) begin
            s_d.flag  = 1'b1;
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.flag;
endmodule

// File: rtl/sc_stat_flags.sv
module sc_stat_flags #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TGT_STD = 25,
    parameter int unsigned TGT_BLK = 23,
    parameter int unsigned TGT_GRD = 22
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           half_tick,
    input  logic                           tx_start,
    input  logic                           tx_en,
    input  logic                           guard_mode,
    input  logic                           block_mode,
    input  logic                           tdr_empty,
    input  logic                           tdr_wr,
    input  logic                           err_sig,
    input  logic                           rx_valid,
    input  logic                           par_err,
    input  logic [DATA_W-1:0]              rx_byte,
    input  logic                           stat_rd,
    input  logic                           stat_wr,
    input  logic [sc_stat_pkg::STAT_W-1:0] stat_wdata,
    output logic                           tend,
    output logic                           ers_flag,
    output logic                           per_flag,
    output logic                           rx_halt,
    output logic                           rdr_load,
    output logic                           rdrf_set,
    output logic [DATA_W-1:0]              rdr_data
);
    import sc_stat_pkg::*;

    typedef struct packed {
        logic              tend;
        logic              tdre_arm;
        logic              rdr_load;
        logic              rdrf_set;
        logic [DATA_W-1:0] rdr_data;
    } top_t;

    top_t s_q, s_d;
    logic expire;
    logic per_set;
    logic accept;
    logic tend_clr;

    sc_etu_timer #(
        .TGT_STD (TGT_STD),
        .TGT_BLK (TGT_BLK),
        .TGT_GRD (TGT_GRD)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tx_start),
        .tick       (half_tick),
        .guard_mode (guard_mode),
        .block_mode (block_mode),
        .expire     (expire)
    );

    sc_armed_flag u_per (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (per_set),
        .rd    (stat_rd),
        .wr    (stat_wr),
        .wbit  (stat_wdata[BIT_PER]),
        .flag  (per_flag)
    );

    sc_armed_flag u_ers (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_sig),
        .rd    (stat_rd),
        .wr    (stat_wr),
        .wbit  (stat_wdata[BIT_ERS]),
        .flag  (ers_flag)
    );

    always_comb begin
        accept   = rx_valid && !per_flag;
        per_set  = accept && par_err;
        tend_clr = tdr_wr || (stat_wr && !stat_wdata[BIT_TDRE] && s_q.tdre_arm);

        s_d          = s_q;
        s_d.rdr_load = accept;
        s_d.rdrf_set = accept && !par_err;
        if (accept) s_d.rdr_data = rx_byte;

        if (tend_clr)                    s_d.tdre_arm = 1'b0;
        else if (stat_rd && tdr_empty)   s_d.tdre_arm = 1'b1;

        if (!tx_en && !ers_flag)         s_d.tend = 1'b1;
        else if (tend_clr)               s_d.tend = 1'b0;
        else if (expire && !ers_flag && tdr_empty) s_d.tend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.tend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tend     = s_q.tend;
    assign rx_halt  = per_flag;
    assign rdr_load = s_q.rdr_load;
    assign rdrf_set = s_q.rdrf_set;
    assign rdr_data = s_q.rdr_data;
endmodule

// File: rtl/sc_stat_flags_chk.sv
module sc_stat_flags_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tdr_wr,
    input logic rx_valid,
    input logic par_err,
    input logic stat_wr,
    input logic tend,
    input logic ers_flag,
    input logic per_flag,
    input logic rx_halt,
    input logic rdr_load,
    input logic rdrf_set
);
    AST_TEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !ers_flag) |=> tend); // R6
    AST_TDR_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tdr_wr) |=> !tend); // R7
    AST_PERR_LOAD_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && par_err && !per_flag) |=> (rdr_load && !rdrf_set && per_flag)); // R9
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_halt) |=> !rdr_load); // R10
    AST_PER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (per_flag && !stat_wr) |=> per_flag); // R11
    AST_ERS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_flag && !stat_wr) |=> ers_flag); // R12
endmodule

bind sc_stat_flags sc_stat_flags_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tdr_wr   (tdr_wr),
    .rx_valid (rx_valid),
    .par_err  (par_err),
    .stat_wr  (stat_wr),
    .tend     (tend),
    .ers_flag (ers_flag),
    .per_flag (per_flag),
    .rx_halt  (rx_halt),
    .rdr_load (rdr_load),
    .rdrf_set (rdrf_set)
);

// File: tb/sc_stat_flags_tb.sv
module sc_stat_flags_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 0, tx_start = 0, tx_en = 0, guard_mode = 0, block_mode = 0;
    logic       tdr_empty = 1, tdr_wr = 0, err_sig = 0, rx_valid = 0, par_err = 0;
    logic [7:0] rx_byte = '0;
    logic       stat_rd = 0, stat_wr = 0;
    logic [2:0] stat_wdata = '1;
    logic       tend, ers_flag, per_flag, rx_halt, rdr_load, rdrf_set;
    logic [7:0] rdr_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sc_stat_flags u_dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .tx_start(tx_start),
        .tx_en(tx_en), .guard_mode(guard_mode), .block_mode(block_mode),
        .tdr_empty(tdr_empty), .tdr_wr(tdr_wr), .err_sig(err_sig),
        .rx_valid(rx_valid), .par_err(par_err), .rx_byte(rx_byte),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .tend(tend), .ers_flag(ers_flag), .per_flag(per_flag), .rx_halt(rx_halt),
        .rdr_load(rdr_load), .rdrf_set(rdrf_set), .rdr_data(rdr_data)
    );

    function automatic int interval(input logic gm, input logic bm);
        if (gm) return 22;
        if (bm) return 23;
        return 25;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick();
        half_tick = 1;
        cyc();
        half_tick = 0;
        repeat ($urandom % 3) cyc();
    endtask

    task automatic start_tx();
        tx_start = 1;
        cyc();
        tx_start = 0;
    endtask

    task automatic clear_tend(input string req);
        tdr_wr = 1;
        cyc();
        tdr_wr = 0;
        chk(req, tend, 0);
    endtask

    task automatic stat_read();
        stat_rd = 1;
        cyc();
        stat_rd = 0;
    endtask

    task automatic stat_write(input logic [2:0] d);
        stat_wdata = d;
        stat_wr = 1;
        cyc();
        stat_wr = 0;
        stat_wdata = '1;
    endtask

    task automatic run_interval(input logic gm, input logic bm, input logic empty_end, input string req);
        int n;
        guard_mode = gm;
        block_mode = bm;
        tx_en = 1;
        tdr_empty = 1;
        clear_tend(req);
        start_tx();
        n = interval(gm, bm);
        for (int k = 1; k < n; k++) begin
            tick();
            if (k == n - 1) chk(req, tend, 0);
        end
        tdr_empty = empty_end;
        tick();
        chk(req, tend, empty_end);
        tdr_empty = 1;
    endtask

    task automatic rx(input logic [7:0] b, input logic pe);
        rx_byte = b;
        par_err = pe;
        rx_valid = 1;
        cyc();
        rx_valid = 0;
        par_err = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7816));
        cyc();
        // R1 reset state
        chk("R1 tend", tend, 1);
        chk("R1 per", per_flag, 0);
        chk("R1 ers", ers_flag, 0);
        chk("R1 halt", rx_halt, 0);
        chk("R1 strobes", {rdr_load, rdrf_set}, 0);
        rst_n = 1;
        cyc();

        // R2 R3 R4 directed intervals
        run_interval(0, 0, 1, "R2");
        run_interval(0, 1, 1, "R3");
        run_interval(1, 0, 1, "R4");
        run_interval(1, 1, 1, "R4");
        for (int i = 0; i < 6; i++) begin
            logic gm, bm;
            gm = 1'($urandom);
            bm = 1'($urandom);
            run_interval(gm, bm, 1, gm ? "R4" : (bm ? "R3" : "R2"));
        end

        // R5 data register not empty at expiry
        run_interval(0, 0, 0, "R5");
        tick();
        tick();
        chk("R5 no late set", tend, 0);

        // R8 restart mid interval
        guard_mode = 0; block_mode = 0;
        clear_tend("R8");
        start_tx();
        for (int k = 0; k < 10; k++) tick();
        start_tx();
        for (int k = 1; k < 25; k++) tick();
        chk("R8 restart", tend, 0);
        tick();
        chk("R8 restart end", tend, 1);

        // R6 hold while transmitter disabled
        clear_tend("R6");
        tx_en = 0;
        cyc();
        chk("R6 hold", tend, 1);
        tdr_wr = 1;
        cyc();
        tdr_wr = 0;
        chk("R6 hold vs write", tend, 1);
        tx_en = 1;
        cyc();

        // R7 software clear needs arming read
        stat_write(3'b110);
        chk("R7 unarmed write", tend, 1);
        tdr_empty = 0;
        stat_read();
        tdr_empty = 1;
        stat_write(3'b110);
        chk("R7 read while full", tend, 1);
        stat_read();
        stat_write(3'b111);
        chk("R7 write one", tend, 1);
        stat_write(3'b110);
        chk("R7 armed clear", tend, 0);

        // R9 parity error load
        rx(8'hA5, 1);
        chk("R9 load", rdr_load, 1);
        chk("R9 no full", rdrf_set, 0);
        chk("R9 data", rdr_data, 8'hA5);
        chk("R9 per", per_flag, 1);
        // R10 blocked
        chk("R10 halt", rx_halt, 1);
        rx(8'h3C, 0);
        chk("R10 blocked", rdr_load, 0);
        chk("R10 data kept", rdr_data, 8'hA5);
        // R11 clear rules
        stat_write(3'b101);
        chk("R11 unarmed", per_flag, 1);
        stat_read();
        stat_write(3'b111);
        chk("R11 write one", per_flag, 1);
        stat_write(3'b101);
        chk("R11 armed clear", per_flag, 0);
        chk("R11 halt off", rx_halt, 0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            rx(b, 0);
            chk("R9 good load", {rdr_load, rdrf_set}, 2'b11);
            chk("R9 good data", rdr_data, b);
        end

        // R12 error signal flag
        clear_tend("R12");
        err_sig = 1;
        cyc();
        err_sig = 0;
        chk("R12 set", ers_flag, 1);
        tx_en = 0;
        cyc();
        chk("R12 no hold", tend, 0);
        tx_en = 1;
        guard_mode = 1;
        start_tx();
        for (int k = 0; k < 22; k++) tick();
        chk("R12 no expiry set", tend, 0);
        stat_write(3'b011);
        chk("R12 unarmed", ers_flag, 1);
        stat_read();
        stat_write(3'b011);
        chk("R12 armed clear", ers_flag, 0);
        tx_en = 0;
        cyc();
        chk("R12 hold after clear", tend, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule